// File: doc/BRIEF.md
# Frame Store Sequencing Controller

This block arbitrates a single external frame memory between a video capture path and a compression engine. Such a memory cannot write and read in the same period. The controller first waits for the memory to report that it is ready. It then waits for an incoming frame to begin and opens a write window for the length of that frame. When the frame ends, it closes the window and pulses a start command to the encoder. It opens a read window only once the encoder reports busy. After the memory engine reports that the whole frame has been read back, the controller waits for the encoder to finish before it accepts another frame.

Frames that begin while the controller is busy with an earlier frame are skipped, and a saturating counter records how many were lost. The memory engines and the encoder sit outside this block. They observe the two window outputs and the start pulse, and they return the busy, done and read-complete indications.

Top module: `frame_store_seq`

## Requirements
- R1: After a synchronous active-low reset, wr_window, rd_window and enc_start are low and drop_count is 0.
- R2: While mem_ready is low after reset, the controller stays in its calibration wait. A frame_start in that period opens no window and is not counted as dropped.
- R3: Once the controller is waiting for a frame, a frame_start sampled high causes wr_window to go high in the following cycle.
- R4: wr_window stays high until frame_end is sampled. In the next cycle wr_window is low and enc_start is high, and enc_start lasts exactly one cycle.
- R5: enc_busy is only sampled after the start pulse. rd_window rises in the cycle after enc_busy is seen high in that wait, and enc_busy during the start-pulse cycle has no effect.
- R6: rd_window stays high until rd_complete is sampled and drops in the next cycle. The controller then waits for enc_done before it again accepts a frame_start.
- R7: wr_window and rd_window are never high in the same cycle.
- R8: After calibration, each frame_start sampled outside the wait-for-frame state adds one to drop_count and leaves both windows unchanged.
- R9: drop_count (8 bits) saturates at 255 and does not wrap.
- R10: drop_clear sets drop_count to 0 in the next cycle. It takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_ready | input | 1 | Memory calibrated and usable |
| frame_start | input | 1 | Start-of-frame strobe from capture |
| frame_end | input | 1 | End-of-frame strobe from capture |
| enc_busy | input | 1 | Encoder has accepted the job |
| enc_done | input | 1 | Encoder has finished the frame |
| rd_complete | input | 1 | Whole frame read back from memory |
| drop_clear | input | 1 | Clears the dropped-frame count |
| wr_window | output | 1 | Memory write phase active |
| rd_window | output | 1 | Memory read phase active |
| enc_start | output | 1 | One-cycle encoder start command |
| drop_count | output | 8 | Saturating count of skipped frames |

## Verification
On every cycle, the assertions check the following properties:
- the write and read windows never overlap;
- the start pulse lasts one cycle;
- each window persists until its closing indication arrives;
- the calibration wait holds while mem_ready is low;
- the counter saturates and obeys a clear.

Only the bench's scenarios can show the full phase order and the exact cycle each window opens. The same applies to ignoring busy during the start pulse, to counting strobes that arrive mid-frame and during the done wait but not during calibration, and to clear winning over an increment.

// File: rtl/fss_pkg.sv
// Shared types for the frame store sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package fss_pkg;
    typedef enum logic [2:0] {
        PH_CAL   = 3'd0,
        PH_IDLE  = 3'd1,
        PH_WRITE = 3'd2,
        PH_KICK  = 3'd3,
        PH_WBUSY = 3'd4,
        PH_READ  = 3'd5,
        PH_WDONE = 3'd6
    } phase_e;
endpackage

// File: rtl/fss_phase_fsm.sv
// Phase sequencer: calibration wait, frame wait, write, encoder kick,
// busy wait, read, done wait. Window and start outputs are registered
// from the next phase. Also flags frame starts that must be skipped.
// Assumes: strobes are synchronous single-cycle or level signals on clk.
module fss_phase_fsm
    import fss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_ready,
    input  logic frame_start,
    input  logic frame_end,
    input  logic enc_busy,
    input  logic enc_done,
    input  logic rd_complete,
    output logic wr_window,
    output logic rd_window,
    output logic enc_start,
    output logic frame_missed
);
    phase_e phase_q, phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_CAL:   if (mem_ready)   phase_d = PH_IDLE;
            PH_IDLE:  if (frame_start) phase_d = PH_WRITE;
            PH_WRITE: if (frame_end)   phase_d = PH_KICK;
            PH_KICK:                   phase_d = PH_WBUSY;
            PH_WBUSY: if (enc_busy)    phase_d = PH_READ;
            PH_READ:  if (rd_complete) phase_d = PH_WDONE;
            PH_WDONE: if (enc_done)    phase_d = PH_IDLE;
            default:                   phase_d = PH_CAL;
        endcase
    end

    // Flag a start that arrives when no new frame can be taken.
    always_comb begin
        frame_missed = frame_start && (phase_q != PH_IDLE) && (phase_q != PH_CAL);
    end

    // Phase register and registered output decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_CAL;
            wr_window <= 1'b0;
            rd_window <= 1'b0;
            enc_start <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            wr_window <= (phase_d == PH_WRITE);
            rd_window <= (phase_d == PH_READ);
            enc_start <= (phase_d == PH_KICK);
        end
    end

    a_r2_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CAL && !mem_ready) |=> (phase_q == PH_CAL && !wr_window));
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start |=> !enc_start);
    a_r4_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_window && !frame_end) |=> wr_window);
    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_window && !rd_complete) |=> rd_window);
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_window && rd_window));
endmodule

// File: rtl/fss_drop_counter.sv
// Saturating counter of skipped frames with a synchronous clear.
// Assumes: clear has priority over increment.
module fss_drop_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count, clear and hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (clr)                        count <= '0;
        else if (inc && count != CNT_MAX)    count <= count + 1'b1;
    end

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/frame_store_seq.sv
// Top of the frame store sequencer: serialises write and read access to
// one frame memory around an encoder and counts skipped frames.
// Assumes: memory engines and encoder are external and synchronous to clk.
module frame_store_seq #(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ready,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              enc_busy,
    input  logic              enc_done,
    input  logic              rd_complete,
    input  logic              drop_clear,
    output logic              wr_window,
    output logic              rd_window,
    output logic              enc_start,
    output logic [DROP_W-1:0] drop_count
);
    logic missed;

    fss_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_ready    (mem_ready),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .enc_busy     (enc_busy),
        .enc_done     (enc_done),
        .rd_complete  (rd_complete),
        .wr_window    (wr_window),
        .rd_window    (rd_window),
        .enc_start    (enc_start),
        .frame_missed (missed)
    );

    fss_drop_counter #(.CNT_W(DROP_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (missed),
        .clr   (drop_clear),
        .count (drop_count)
    );
endmodule

// File: tb/frame_store_seq_tb_top.sv
`timescale 1ns/1ps
module frame_store_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_ready = 0, frame_start = 0, frame_end = 0, enc_busy = 0;
    logic enc_done = 0, rd_complete = 0, drop_clear = 0;
    logic wr_window, rd_window, enc_start;
    logic [7:0] drop_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic     wr;
        logic     rd;
        logic     st;
        int       cnt;
        string    req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    frame_store_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready),
        .frame_start(frame_start), .frame_end(frame_end),
        .enc_busy(enc_busy), .enc_done(enc_done),
        .rd_complete(rd_complete), .drop_clear(drop_clear),
        .wr_window(wr_window), .rd_window(rd_window),
        .enc_start(enc_start), .drop_count(drop_count)
    );

    // Driver: apply one cycle of inputs, push the expected post-edge outputs.
    task automatic cyc(input bit mr, fs, fe, bz, dn, rc, cl,
                       input bit ewr, erd, est, input int ecnt, input string req);
        exp_t e;
        @(negedge clk);
        mem_ready = mr; frame_start = fs; frame_end = fe; enc_busy = bz;
        enc_done = dn; rd_complete = rc; drop_clear = cl;
        @(posedge clk);
        e.wr = ewr; e.rd = erd; e.st = est; e.cnt = ecnt; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (wr_window !== e.wr || rd_window !== e.rd ||
                    enc_start !== e.st || int'(drop_count) != e.cnt) begin
                    errors++;
                    $display("FAIL %s: got wr=%b rd=%b st=%b cnt=%0d exp wr=%b rd=%b st=%b cnt=%0d",
                             e.req, wr_window, rd_window, enc_start, drop_count,
                             e.wr, e.rd, e.st, e.cnt);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (wr_window || rd_window || enc_start || drop_count != 0) begin
            errors++;
            $display("FAIL R1: got wr=%b rd=%b st=%b cnt=%0d exp all zero",
                     wr_window, rd_window, enc_start, drop_count);
        end
        // R2: calibration wait ignores frame_start and does not count it
        cyc(0,1,0,0,0,0,0, 0,0,0,0, "R2");
        cyc(0,0,0,0,0,0,0, 0,0,0,0, "R2");
        cyc(1,0,0,0,0,0,0, 0,0,0,0, "R2");
        // R3: start opens write window
        cyc(1,1,0,0,0,0,0, 1,0,0,0, "R3");
        // R8: start mid-frame counted, window unchanged
        cyc(1,1,0,0,0,0,0, 1,0,0,1, "R8");
        cyc(1,0,0,0,0,0,0, 1,0,0,1, "R4");
        // R4: end closes write, start pulse one cycle
        cyc(1,0,1,0,0,0,0, 0,0,1,1, "R4");
        // R5: busy during pulse cycle ignored
        cyc(1,0,0,1,0,0,0, 0,0,0,1, "R5");
        cyc(1,0,0,0,0,0,0, 0,0,0,1, "R5");
        cyc(1,0,0,1,0,0,0, 0,1,0,1, "R5");
        // R6: read window held until complete
        cyc(1,0,0,0,0,0,0, 0,1,0,1, "R6");
        cyc(1,0,0,0,0,1,0, 0,0,0,1, "R6");
        // R8: start during done wait is skipped
        cyc(1,1,0,0,0,0,0, 0,0,0,2, "R8");
        cyc(1,0,0,0,1,0,0, 0,0,0,2, "R6");
        // R10: clear
        cyc(1,0,0,0,0,0,1, 0,0,0,0, "R10");
        // R3 with simultaneous clear
        cyc(1,1,0,0,0,0,1, 1,0,0,0, "R3");
        // R9: saturation while writing
        for (int i = 0; i < 260; i++)
            cyc(1,1,0,0,0,0,0, 1,0,0,(i + 1 > 255) ? 255 : i + 1, "R9");
        // R10: clear beats increment
        cyc(1,1,0,0,0,0,1, 1,0,0,0, "R10");
        cyc(1,0,1,0,0,0,0, 0,0,1,0, "R4");
        cyc(1,0,0,1,0,0,0, 0,0,0,0, "R5");
        cyc(1,0,0,1,0,0,0, 0,1,0,0, "R7");
        cyc(1,0,0,0,0,1,0, 0,0,0,0, "R6");
        cyc(1,0,0,0,1,0,0, 0,0,0,0, "R6");
        cyc(1,1,0,0,0,0,0, 1,0,0,0, "R3");
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule